// File: doc/BRIEF.md
# DS3 Receive Alarm Interrupt Controller

This block sits behind a DS3 receive framer and turns its alarm and error indications into one active-high interrupt for a microprocessor. It takes the present AIS, LOS, Idle, OOF and AIC states as levels. It also takes single-cycle parity-error and CP-bit-error pulses. From the two X bits seen at each frame boundary, it works out the far-end receive failure (FERF) state itself.

A change of any level condition latches a sticky status bit. This happens both when the condition appears and when it goes away. An error pulse latches its own status bit directly. A status bit latches only while its enable bit is set. The interrupt output is high whenever any status bit is held.

Software uses an 8-bit register interface with three registers:
- a configuration/status register, which shows the live alarm states and holds three configuration bits;
- an interrupt-enable register;
- an interrupt-status register, which empties itself when read.

After an interrupt, software reads the status register to find the source. It then reads the configuration/status register to learn the present state of that condition.

Top module: `ds3_rx_alarm_irq`

## Requirements
- R1: The FERF state becomes 1 after 3 consecutive frame strobes (`frameStb` high) that each sample `xBits == 2'b00`. It becomes 0 after 3 consecutive strobes that each sample `xBits != 2'b00`. A strobe that matches the present FERF state restarts the count. Cycles without a strobe do not affect the count.
- R2: A change of the LOS, AIS, Idle, AIC, OOF or FERF state sets its status bit on the clock edge after the change. This applies both when the condition is declared and when it is cleared.
- R3: A high cycle on `parErrPulse` sets status bit 0, and a high cycle on `cpErrPulse` sets status bit 7. No edge detection is applied to these pulses.
- R4: The enable register is at address 0x12 and every bit is read/write. The bit map is:
  - 7 = CP-bit error
  - 6 = LOS
  - 5 = AIS
  - 4 = Idle
  - 3 = FERF
  - 2 = AIC
  - 1 = OOF
  - 0 = parity error
- R5: A status bit latches only if its enable bit is 1 at the time of the event. An event that arrives while the bit is disabled is lost, even if the bit is enabled later.
- R6: The status register is at address 0x13 and uses the same bit map as the enable register. A read with `regRdEn` high returns the held bits and clears all of them on that clock edge.
- R7: An enabled event that arrives in the same cycle as a status read leaves its bit set after the read.
- R8: The configuration/status register is at address 0x10. Bit 7 shows live AIS, bit 6 live LOS, bit 5 live Idle and bit 4 live OOF. Bit 3 reads 0. Bits 2..0 are read/write configuration storage.
- R9: `irqOut` is 1 exactly when at least one status bit is held.
- R10: A synchronous active-high reset clears the enable register, the status register, the configuration bits and the FERF state.
- R11: Writes to 0x13 or to any unmapped address change no register. Reads of unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frameStb | input | 1 | One-cycle strobe at each frame boundary; `xBits` is sampled here |
| xBits | input | 2 | The two X bits of the current frame |
| aisIn | input | 1 | Present AIS state |
| losIn | input | 1 | Present LOS state |
| idleIn | input | 1 | Present Idle state |
| oofIn | input | 1 | Present out-of-frame state |
| aicIn | input | 1 | Present AIC state |
| parErrPulse | input | 1 | One-cycle parity error pulse |
| cpErrPulse | input | 1 | One-cycle CP-bit error pulse |
| regAddr | input | 8 | Register address |
| regWrEn | input | 1 | Write strobe |
| regWrData | input | 8 | Write data |
| regRdEn | input | 1 | Read strobe; clears the status register when the address is 0x13 |
| regRdData | output | 8 | Read data for `regAddr` (combinational) |
| irqOut | output | 1 | Interrupt request, active high |

## Verification
The bench drives FERF runs of two, three and interrupted lengths. A filter that counted non-consecutive strobes or declared one frame early would show the FERF bit at the wrong time. It checks the falling edge of each condition, where a design that latched only assertions would stay silent. It sends an error pulse in the very cycle of a status read, where a design that let the clear win would lose the event. It also enables a source after its condition has already changed, where a design that latched regardless of the enable would raise a stale interrupt. Finally, it resets while FERF is declared and then expects a fresh declaration after three strobes, which a design that kept the FERF state through reset would miss.

// File: rtl/ds3_alarm_pkg.sv
package ds3_alarm_pkg;

  localparam int REG_W = 8;
  localparam int LIVE_W = 4;
  localparam int CFG_W = 3;

  // status / enable bit positions (software decodes these)
  localparam int BIT_CPERR = 7;
  localparam int BIT_LOS   = 6;
  localparam int BIT_AIS   = 5;
  localparam int BIT_IDLE  = 4;
  localparam int BIT_FERF  = 3;
  localparam int BIT_AIC   = 2;
  localparam int BIT_OOF   = 1;
  localparam int BIT_PERR  = 0;

  // sources that are levels (edge detected) versus pulses
  localparam logic [REG_W-1:0] LEVEL_MASK = 8'b0111_1110;

  localparam logic [7:0] ADDR_CFG    = 8'h10;
  localparam logic [7:0] ADDR_ENABLE = 8'h12;
  localparam logic [7:0] ADDR_STATUS = 8'h13;

  typedef struct packed {
    logic [REG_W-1:0]  srcEvt;     // per-source event this cycle
    logic [LIVE_W-1:0] liveState;  // {ais, los, idle, oof}
    logic              selCfg;
    logic              selEnable;
    logic              selStatus;
    logic              wrCfg;
    logic              wrEnable;
    logic              rdStatus;
    logic [REG_W-1:0]  wrData;
  } ctrlStrobes_t;

endpackage

// File: rtl/ds3_ferf_filter.sv
module ds3_ferf_filter #(
  parameter int FRAMES = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       frameStb,
  input  logic [1:0] xBits,
  output logic       ferfState
);

  localparam int CW = (FRAMES < 2) ? 1 : $clog2(FRAMES);
  localparam logic [CW-1:0] LAST = CW'(FRAMES - 1);

  logic [CW-1:0] runCnt;
  logic          candidate;

  assign candidate = (xBits == 2'b00);

  always_ff @(posedge clk) begin
    if (rst) begin
      ferfState <= 1'b0;
      runCnt    <= '0;
    end else if (frameStb) begin
      if (candidate == ferfState) begin
        runCnt <= '0;
      end else if (runCnt == LAST) begin
        ferfState <= candidate;
        runCnt    <= '0;
      end else begin
        runCnt <= runCnt + 1'b1;
      end
    end
  end

  // R1: the state only moves on a frame strobe
  a_r1_ferf_on_strobe: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$stable(ferfState)) |-> $past(frameStb));

  // R10: reset leaves FERF cleared
  a_r10_ferf_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !ferfState);

endmodule

// File: rtl/ds3_alarm_ctrl.sv
module ds3_alarm_ctrl
  import ds3_alarm_pkg::*;
#(
  parameter int FERF_FRAMES = 3,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frameStb,
  input  logic [1:0]        xBits,
  input  logic              aisIn,
  input  logic              losIn,
  input  logic              idleIn,
  input  logic              oofIn,
  input  logic              aicIn,
  input  logic              parErrPulse,
  input  logic              cpErrPulse,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [REG_W-1:0]  regWrData,
  input  logic              regRdEn,
  output ctrlStrobes_t      str
);

  logic             ferfState;
  logic [REG_W-1:0] srcVec;
  logic [REG_W-1:0] evtVec;
  logic             hitCfg, hitEnable, hitStatus;

  ds3_ferf_filter #(.FRAMES(FERF_FRAMES)) ferf_i (
    .clk(clk), .rst(rst), .frameStb(frameStb), .xBits(xBits),
    .ferfState(ferfState)
  );

  always_comb begin
    srcVec = '0;
    srcVec[BIT_CPERR] = cpErrPulse;
    srcVec[BIT_LOS]   = losIn;
    srcVec[BIT_AIS]   = aisIn;
    srcVec[BIT_IDLE]  = idleIn;
    srcVec[BIT_FERF]  = ferfState;
    srcVec[BIT_AIC]   = aicIn;
    srcVec[BIT_OOF]   = oofIn;
    srcVec[BIT_PERR]  = parErrPulse;
  end

  for (genvar i = 0; i < REG_W; i++) begin : g_src
    if (LEVEL_MASK[i]) begin : g_level
      logic prevQ;
      always_ff @(posedge clk) begin
        if (rst) prevQ <= 1'b0;
        else     prevQ <= srcVec[i];
      end
      assign evtVec[i] = srcVec[i] ^ prevQ;
    end else begin : g_pulse
      assign evtVec[i] = srcVec[i];
    end
  end

  assign hitCfg    = (regAddr == ADDR_W'(ADDR_CFG));
  assign hitEnable = (regAddr == ADDR_W'(ADDR_ENABLE));
  assign hitStatus = (regAddr == ADDR_W'(ADDR_STATUS));

  always_comb begin
    str.srcEvt    = evtVec;
    str.liveState = {aisIn, losIn, idleIn, oofIn};
    str.selCfg    = hitCfg;
    str.selEnable = hitEnable;
    str.selStatus = hitStatus;
    str.wrCfg     = regWrEn & hitCfg;
    str.wrEnable  = regWrEn & hitEnable;
    str.rdStatus  = regRdEn & hitStatus;
    str.wrData    = regWrData;
  end

  // R2: a level event means the source moved since the last cycle
  a_r2_level_event_is_change: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && str.srcEvt[BIT_AIS]) |-> (aisIn != $past(aisIn)));

endmodule

// File: rtl/ds3_alarm_dp.sv
module ds3_alarm_dp
  import ds3_alarm_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  ctrlStrobes_t     str,
  output logic [REG_W-1:0] rdData,
  output logic             irqOut
);

  logic [REG_W-1:0] enableReg;
  logic [REG_W-1:0] statusReg;
  logic [CFG_W-1:0] cfgReg;
  logic [REG_W-1:0] latchVec;
  logic [REG_W-1:0] statusNext;

  assign latchVec   = str.srcEvt & enableReg;
  assign statusNext = (str.rdStatus ? '0 : statusReg) | latchVec;

  always_ff @(posedge clk) begin
    if (rst) begin
      enableReg <= '0;
      statusReg <= '0;
      cfgReg    <= '0;
    end else begin
      statusReg <= statusNext;
      if (str.wrEnable) enableReg <= str.wrData;
      if (str.wrCfg)    cfgReg    <= str.wrData[CFG_W-1:0];
    end
  end

  always_comb begin
    rdData = '0;
    if (str.selCfg)         rdData = {str.liveState, 1'b0, cfgReg};
    else if (str.selEnable) rdData = enableReg;
    else if (str.selStatus) rdData = statusReg;
  end

  assign irqOut = |statusReg;

  // R5: newly set bits were enabled in the previous cycle
  a_r5_only_enabled_latch: assert property (@(posedge clk) disable iff (rst)
    !rst |=> ((statusReg & ~$past(statusReg) & ~$past(enableReg)) == '0));

  // R6: a read with no enabled event empties the register
  a_r6_read_clears: assert property (@(posedge clk) disable iff (rst)
    (str.rdStatus && ((str.srcEvt & enableReg) == '0)) |=> (statusReg == '0));

  // R7: enabled events arriving with a read survive it
  a_r7_event_wins: assert property (@(posedge clk) disable iff (rst)
    str.rdStatus |=> ((statusReg & $past(str.srcEvt & enableReg)) == $past(str.srcEvt & enableReg)));

  // R9: the interrupt only drops after a status read
  a_r9_irq_drop_on_read: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $fell(irqOut)) |-> $past(str.rdStatus));

endmodule

// File: rtl/ds3_rx_alarm_irq.sv
module ds3_rx_alarm_irq
  import ds3_alarm_pkg::*;
#(
  parameter int FERF_FRAMES = 3,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frameStb,
  input  logic [1:0]        xBits,
  input  logic              aisIn,
  input  logic              losIn,
  input  logic              idleIn,
  input  logic              oofIn,
  input  logic              aicIn,
  input  logic              parErrPulse,
  input  logic              cpErrPulse,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [REG_W-1:0]  regWrData,
  input  logic              regRdEn,
  output logic [REG_W-1:0]  regRdData,
  output logic              irqOut
);

  ctrlStrobes_t str;

  ds3_alarm_ctrl #(.FERF_FRAMES(FERF_FRAMES), .ADDR_W(ADDR_W)) ctrl_i (
    .clk(clk), .rst(rst), .frameStb(frameStb), .xBits(xBits),
    .aisIn(aisIn), .losIn(losIn), .idleIn(idleIn), .oofIn(oofIn),
    .aicIn(aicIn), .parErrPulse(parErrPulse), .cpErrPulse(cpErrPulse),
    .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdEn(regRdEn), .str(str)
  );

  ds3_alarm_dp dp_i (
    .clk(clk), .rst(rst), .str(str), .rdData(regRdData), .irqOut(irqOut)
  );

endmodule

// File: tb/ds3_rx_alarm_irq_tb.sv
module ds3_rx_alarm_irq_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       frameStb = 1'b0;
  logic [1:0] xBits = 2'b11;
  logic       aisIn = 0, losIn = 0, idleIn = 0, oofIn = 0, aicIn = 0;
  logic       parErrPulse = 0, cpErrPulse = 0;
  logic [7:0] regAddr = 8'h00;
  logic       regWrEn = 0;
  logic [7:0] regWrData = 8'h00;
  logic       regRdEn = 0;
  logic [7:0] regRdData;
  logic       irqOut;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2 clk = ~clk;  // 250 MHz

  ds3_rx_alarm_irq dut_i (
    .clk(clk), .rst(rst), .frameStb(frameStb), .xBits(xBits),
    .aisIn(aisIn), .losIn(losIn), .idleIn(idleIn), .oofIn(oofIn),
    .aicIn(aicIn), .parErrPulse(parErrPulse), .cpErrPulse(cpErrPulse),
    .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdEn(regRdEn), .regRdData(regRdData), .irqOut(irqOut)
  );

  // ---------------- behavioural reference model ----------------
  int mEn = 0, mStat = 0, mCfg = 0;
  int mFerf = 0, mFerfSeen = 0, mStreak = 0;
  int mPrev[6];  // los, ais, idle, ferf, aic, oof

  always @(posedge clk) begin
    int ev;
    int cur[6];
    if (rst) begin
      mEn = 0; mStat = 0; mCfg = 0; mFerf = 0; mFerfSeen = 0; mStreak = 0;
      foreach (mPrev[k]) mPrev[k] = 0;
    end else begin
      cur[0] = losIn; cur[1] = aisIn; cur[2] = idleIn;
      cur[3] = mFerf; cur[4] = aicIn; cur[5] = oofIn;
      ev = 0;
      if (cpErrPulse) ev += 128;
      if (cur[0] != mPrev[0]) ev += 64;
      if (cur[1] != mPrev[1]) ev += 32;
      if (cur[2] != mPrev[2]) ev += 16;
      if (cur[3] != mPrev[3]) ev += 8;
      if (cur[4] != mPrev[4]) ev += 4;
      if (cur[5] != mPrev[5]) ev += 2;
      if (parErrPulse) ev += 1;
      if (regRdEn && regAddr == 8'h13) mStat = 0;
      mStat = mStat | (ev & mEn);
      if (regWrEn && regAddr == 8'h12) mEn = regWrData;
      if (regWrEn && regAddr == 8'h10) mCfg = regWrData % 8;
      foreach (mPrev[k]) mPrev[k] = cur[k];
      if (frameStb) begin
        mFerfSeen = (xBits == 2'b00) ? 1 : 0;
        if (mFerfSeen == mFerf) mStreak = 0;
        else begin
          mStreak++;
          if (mStreak == 3) begin mFerf = mFerfSeen; mStreak = 0; end
        end
      end
    end
  end

  function automatic int modelRead(logic [7:0] a);
    if (a == 8'h10) return aisIn * 128 + losIn * 64 + idleIn * 32 + oofIn * 16 + mCfg;
    if (a == 8'h12) return mEn;
    if (a == 8'h13) return mStat;
    return 0;
  endfunction

  // compare every clock, just after the edge
  always @(posedge clk) begin
    #1;
    if (!done) begin
      checks++;
      if (irqOut !== (mStat != 0)) begin
        fails++;
        $display("FAIL R9 irqOut: actual %0b expected %0b", irqOut, mStat != 0);
      end
      checks++;
      if (regRdData !== 8'(modelRead(regAddr))) begin
        fails++;
        $display("FAIL R4 R6 R8 R11 read @%h: actual %h expected %h",
                 regAddr, regRdData, 8'(modelRead(regAddr)));
      end
    end
  end

  // ---------------- directed stimulus ----------------
  task automatic chk(logic [7:0] act, logic [7:0] exp, string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk); regAddr = a; regWrData = d; regWrEn = 1;
    @(negedge clk); regWrEn = 0;
  endtask

  task automatic rd(logic [7:0] a, bit clr, logic [7:0] exp, string tag);
    @(negedge clk); regAddr = a; regRdEn = clr;
    #1 chk(regRdData, exp, tag);
    @(negedge clk); regRdEn = 0;
  endtask

  task automatic strobe(logic [1:0] x);
    @(negedge clk); xBits = x; frameStb = 1;
    @(negedge clk); frameStb = 0; xBits = 2'b10;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    // R10 reset state
    rd(8'h12, 0, 8'h00, "R10 enable after reset");
    rd(8'h13, 0, 8'h00, "R10 status after reset");
    chk({7'd0, irqOut}, 8'h00, "R9 irq after reset");

    // R4 / R8 register access
    wr(8'h12, 8'hFF);
    rd(8'h12, 0, 8'hFF, "R4 enable readback");
    wr(8'h10, 8'hFF);
    rd(8'h10, 0, 8'h07, "R8 cfg bits only");

    // R2 declare and clear of AIS, R6 clear on read
    @(negedge clk); aisIn = 1;
    rd(8'h10, 0, 8'h87, "R8 live AIS bit");
    rd(8'h13, 1, 8'h20, "R2 AIS declared");
    rd(8'h13, 1, 8'h00, "R6 status cleared by read");
    @(negedge clk); aisIn = 0;
    rd(8'h13, 1, 8'h20, "R2 AIS cleared");

    // R5 enable gating
    wr(8'h12, 8'h02);
    @(negedge clk); losIn = 1; oofIn = 1;
    rd(8'h13, 0, 8'h02, "R5 only OOF latched");
    chk({7'd0, irqOut}, 8'h01, "R9 irq set");
    rd(8'h13, 1, 8'h02, "R6 read returns held bits");
    chk({7'd0, irqOut}, 8'h00, "R9 irq cleared");
    wr(8'h12, 8'hFF);
    rd(8'h13, 1, 8'h00, "R5 no late latch of LOS");
    @(negedge clk); losIn = 0; oofIn = 0;
    rd(8'h13, 1, 8'h42, "R2 LOS and OOF cleared");
    @(negedge clk); idleIn = 1; aicIn = 1;
    rd(8'h10, 0, 8'h27, "R8 live Idle bit");
    rd(8'h13, 1, 8'h14, "R2 Idle and AIC declared");

    // R3 pulses
    @(negedge clk); parErrPulse = 1;
    @(negedge clk); parErrPulse = 0;
    rd(8'h13, 1, 8'h01, "R3 parity pulse");
    @(negedge clk); cpErrPulse = 1;
    @(negedge clk); cpErrPulse = 0;
    rd(8'h13, 1, 8'h80, "R3 CP-bit pulse");

    // R7 event during read
    @(negedge clk); regAddr = 8'h13; regRdEn = 1; parErrPulse = 1;
    #1 chk(regRdData, 8'h00, "R7 pre-read value");
    @(negedge clk); regRdEn = 0; parErrPulse = 0;
    rd(8'h13, 1, 8'h01, "R7 event survives read");

    // R1 FERF filter
    strobe(2'b00); strobe(2'b00);
    rd(8'h13, 0, 8'h00, "R1 two frames not enough");
    strobe(2'b00);
    rd(8'h13, 1, 8'h08, "R1 FERF declared on third");
    strobe(2'b01); strobe(2'b10); strobe(2'b00); strobe(2'b11); strobe(2'b01);
    rd(8'h13, 0, 8'h00, "R1 interrupted run no clear");
    strobe(2'b11);
    rd(8'h13, 1, 8'h08, "R1 FERF cleared");

    // R11 ignored writes and unmapped reads
    @(negedge clk); cpErrPulse = 1;
    @(negedge clk); cpErrPulse = 0;
    wr(8'h13, 8'h00);
    rd(8'h13, 0, 8'h80, "R11 status write ignored");
    wr(8'h20, 8'h00);
    rd(8'h20, 0, 8'h00, "R11 unmapped read zero");
    rd(8'h12, 0, 8'hFF, "R11 enable untouched");
    rd(8'h10, 0, 8'h27, "R11 cfg untouched");

    // R10 reset with FERF declared
    strobe(2'b00); strobe(2'b00); strobe(2'b00);
    @(negedge clk); rst = 1; idleIn = 0; aicIn = 0;
    @(negedge clk); rst = 0;
    rd(8'h12, 0, 8'h00, "R10 enable cleared");
    rd(8'h13, 0, 8'h00, "R10 status cleared");
    rd(8'h10, 0, 8'h00, "R10 cfg cleared");
    wr(8'h12, 8'h08);
    strobe(2'b00); strobe(2'b00); strobe(2'b00);
    rd(8'h13, 1, 8'h08, "R10 FERF restarted from zero");

    repeat (3) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule